// File: doc/BRIEF.md
# Memory-Based Multi-Tap Delay Line

This block is a delay line for signal-processing datapaths such as FIR filters and correlators. Samples of `W` bits enter one per shift. The block presents `N` delayed copies side by side on one output word. Adjacent copies are `M` shifts apart. The history is held in an inferred RAM used as a ring, not in a flip-flop chain. Each RAM word packs all `N` taps of one ring position. One read port and one separate write port therefore serve every tap in the same cycle.

A shift is a clock edge at which `shift_en` is high. At that edge the new sample is taken, and the tap word is updated at the same edge. When `shift_en` is low, the history and the outputs stay as they are. After a synchronous reset the outputs read zero until the ring has filled. A flag then marks that every tap holds a real sample. The optional output register adds exactly one clock of latency to the taps and to the flag.

Configurations are rejected at elaboration when either limit below is exceeded:
- `W*M*N` exceeds 9216 bits.
- `W*N` exceeds 36 bits.

Top module: `mem_tap_delay`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `taps_out` is all zeros and `taps_valid` is low after that edge.
- R2: Count the shifts since reset from 0, and let shift j write sample x_j. After shift j with j >= M*N, field k of `taps_out` holds x_{j-k*M}, for k = 1..N. Field k is bits [k*W-1:(k-1)*W], so tap 1 sits in the least-significant W bits. This value is visible after the edge of shift j when `OUT_REG`=0.
- R3: A clock edge with `shift_en` low consumes no sample. The outputs keep their values, and the tap sequence resumes exactly at the next shift.
- R4: `taps_valid` rises after shift j = M*N, the shift that follows M*N earlier samples since reset. Before that, `taps_out` is all zeros.
- R5: With `OUT_REG`=1, `taps_out` and `taps_valid` equal the values an `OUT_REG`=0 instance shows one clock earlier, for every clock, including clocks without a shift. On a reset edge the outputs clear.
- R6: With M=1, a shift in the clock right after another shift still yields exact taps. Here the read and the pending write hit the same RAM word.
- R7: A reset in mid-stream restarts filling. The outputs read zero until M*N new samples have entered, and the tap values never mix samples from before and after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Take `sample_in` and advance the history at this edge |
| sample_in | input | W | New sample |
| taps_out | output | W*N | All taps; tap 1 in the low W bits |
| taps_valid | output | 1 | Every tap holds a sample written since reset |

## Verification
An incrementing run through the fill shows whether the valid edge lands on the right shift and whether tap k picks the sample k*M back. Any off-by-one in the ring pointer shows up as a wrong value. Irregular shift-enable patterns tell apart designs that advance on idle clocks from those that hold. Alternating all-ones and all-zeros samples expose swapped or misplaced tap fields. A mid-stream reset shows whether stale ring contents leak into the new stream. Three instances run side by side on the same input:
- the plain instance;
- the same geometry with the output register, which separates a one-clock delay from any other change;
- a spacing-of-one geometry, which forces back-to-back read and write of one RAM word.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int unsigned STORE_BITS_MAX = 9216;
    localparam int unsigned BUS_BITS_MAX   = 36;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/msr_store.sv
module msr_store #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_d, rd_q;

    // a pending write to the word being read is forwarded
    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = (wr_en && (wr_addr == rd_addr)) ? wr_data : mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    a_r6_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < int'(DEPTH)));

    a_r6_read_in_range: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(rd_addr) < int'(DEPTH)));

endmodule

// File: rtl/msr_seq.sv
module msr_seq #(
    parameter int unsigned W  = 8,
    parameter int unsigned M  = 4,
    parameter int unsigned N  = 2,
    parameter int unsigned AW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic [W-1:0]    sample_in,
    input  logic [W*N-1:0]  rd_data,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [W*N-1:0]  wr_data,
    output logic [W*N-1:0]  taps_o,
    output logic            valid_o
);

    localparam int unsigned D  = M * N;
    localparam int unsigned FW = $clog2(D + 1);
    localparam int unsigned BW = W * N;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [FW-1:0] fill;
        logic          valid;
        logic          pend;
        logic [AW-1:0] paddr;
        logic [W-1:0]  samp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = 1'b0;
        if (shift_en) begin
            s_d.pend  = 1'b1;
            s_d.paddr = s_q.wp;
            s_d.samp  = sample_in;
            s_d.wp    = (s_q.wp == AW'(M - 1)) ? '0 : s_q.wp + 1'b1;
            if (s_q.fill != FW'(D)) begin
                s_d.fill = s_q.fill + 1'b1;
            end else begin
                s_d.valid = 1'b1;
            end
        end
        if (rst) begin
            s_d.wp    = '0;
            s_d.fill  = '0;
            s_d.valid = 1'b0;
            s_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // word for ring slot: previous taps moved up one field, newest sample at the bottom
    generate
        if (N == 1) begin : g_single
            assign wr_data = s_q.samp;
        end else begin : g_multi
            assign wr_data = {rd_data[BW-W-1:0], s_q.samp};
        end
    endgenerate

    assign rd_en   = shift_en;
    assign rd_addr = s_q.wp;
    assign wr_en   = s_q.pend;
    assign wr_addr = s_q.paddr;
    assign taps_o  = s_q.valid ? rd_data : '0;
    assign valid_o = s_q.valid;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (s_q.wp == '0 && !s_q.valid && s_q.fill == '0 && taps_o == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_en) |=> ($stable(taps_o) && $stable(valid_o) && $stable(s_q.wp)));

    a_r4_fill_limit: assert property (@(posedge clk) disable iff (rst)
        int'(s_q.fill) <= int'(D));

    a_r4_valid_onset: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.valid) |-> ($past(shift_en) && $past(s_q.fill) == FW'(D)));

    a_r2_ptr_range: assert property (@(posedge clk) disable iff (rst)
        int'(s_q.wp) < int'(M));

endmodule

// File: rtl/msr_outstage.sv
module msr_outstage #(
    parameter int unsigned BW      = 8,
    parameter bit          OUT_REG = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] taps_i,
    input  logic          valid_i,
    output logic [BW-1:0] taps_o,
    output logic          valid_o
);

    generate
        if (OUT_REG) begin : g_reg
            typedef struct packed {
                logic [BW-1:0] taps;
                logic          valid;
            } os_t;

            os_t o_d, o_q;

            always_comb begin
                o_d.taps  = taps_i;
                o_d.valid = valid_i;
                if (rst) begin
                    o_d = '0;
                end
            end

            always_ff @(posedge clk) begin
                o_q <= o_d;
            end

            assign taps_o  = o_q.taps;
            assign valid_o = o_q.valid;

            a_r5_one_clock: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (taps_o == $past(taps_i) && valid_o == $past(valid_i)));
        end else begin : g_pass
            assign taps_o  = taps_i;
            assign valid_o = valid_i;
        end
    endgenerate

endmodule

// File: rtl/mem_tap_delay.sv
module mem_tap_delay #(
    parameter int unsigned W       = 8,
    parameter int unsigned M       = 4,
    parameter int unsigned N       = 2,
    parameter bit          OUT_REG = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic [W-1:0]   sample_in,
    output logic [W*N-1:0] taps_out,
    output logic           taps_valid
);

    localparam int unsigned BW = W * N;
    localparam int unsigned AW = msr_pkg::addr_bits(M);

    generate
        if (W * M * N > msr_pkg::STORE_BITS_MAX) begin : g_too_deep
            $error("delay line storage W*M*N exceeds the RAM capacity");
        end
        if (BW > msr_pkg::BUS_BITS_MAX) begin : g_too_wide
            $error("tap bus W*N exceeds the RAM word width");
        end
        if (W == 0 || M == 0 || N == 0) begin : g_empty
            $error("W, M and N must all be at least one");
        end
    endgenerate

    logic          rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [BW-1:0] rd_data, wr_data, taps_raw;
    logic          valid_raw;

    msr_seq #(.W(W), .M(M), .N(N), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .sample_in (sample_in),
        .rd_data   (rd_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .taps_o    (taps_raw),
        .valid_o   (valid_raw)
    );

    msr_store #(.WIDTH(BW), .DEPTH(M), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    msr_outstage #(.BW(BW), .OUT_REG(OUT_REG)) u_out (
        .clk     (clk),
        .rst     (rst),
        .taps_i  (taps_raw),
        .valid_i (valid_raw),
        .taps_o  (taps_out),
        .valid_o (taps_valid)
    );

endmodule

// File: tb/sim_mem_tap_delay.sv
`timescale 1ns/1ps
module sim_mem_tap_delay;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [5:0] din = '0;

    always #2.5 clk = ~clk;

    logic [11:0] t0, t1;
    logic        v0, v1;
    logic [23:0] t2;
    logic        v2;

    mem_tap_delay #(.W(4), .M(3), .N(3), .OUT_REG(1'b0)) u0 (
        .clk(clk), .rst(rst), .shift_en(en), .sample_in(din[3:0]),
        .taps_out(t0), .taps_valid(v0));

    mem_tap_delay #(.W(4), .M(3), .N(3), .OUT_REG(1'b1)) u1 (
        .clk(clk), .rst(rst), .shift_en(en), .sample_in(din[3:0]),
        .taps_out(t1), .taps_valid(v1));

    mem_tap_delay #(.W(6), .M(1), .N(4), .OUT_REG(1'b0)) u2 (
        .clk(clk), .rst(rst), .shift_en(en), .sample_in(din),
        .taps_out(t2), .taps_valid(v2));

    logic [5:0]  hist [1024];
    int          cnt = 0;
    logic [11:0] e0 = '0, e1 = '0;
    logic        ev0 = 1'b0, ev1 = 1'b0;
    logic [23:0] e2 = '0;
    logic        ev2 = 1'b0;
    string       tag = "R1";
    bit          post_rst = 1'b0;
    int          checks = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic r, input logic e, input logic [5:0] d);
        @(negedge clk);
        chk(tag, "u0 taps", {12'h0, t0}, {12'h0, e0});
        chk((tag == "R2") ? "R4" : tag, "u0 valid", {23'h0, v0}, {23'h0, ev0});
        chk("R5", "u1 taps", {12'h0, t1}, {12'h0, e1});
        chk("R5", "u1 valid", {23'h0, v1}, {23'h0, ev1});
        chk("R6", "u2 taps", t2, e2);
        chk("R6", "u2 valid", {23'h0, v2}, {23'h0, ev2});
        rst = r; en = e; din = d;
        e1  = r ? '0 : e0;
        ev1 = r ? 1'b0 : ev0;
        if (r) begin
            if (cnt > 0) post_rst = 1'b1;
            cnt = 0; e0 = '0; ev0 = 1'b0; e2 = '0; ev2 = 1'b0;
        end else if (e) begin
            if (cnt >= 9) begin
                for (int k = 1; k <= 3; k++)
                    e0[(k-1)*4 +: 4] = hist[(cnt - k*3) % 1024][3:0];
                ev0 = 1'b1;
            end
            if (cnt >= 4) begin
                for (int k = 1; k <= 4; k++)
                    e2[(k-1)*6 +: 6] = hist[(cnt - k) % 1024];
                ev2 = 1'b1;
            end
            hist[cnt % 1024] = d;
            cnt++;
        end
        if (ev0) post_rst = 1'b0;
        if (r)              tag = "R1";
        else if (post_rst)  tag = "R7";
        else if (!e)        tag = "R3";
        else if (ev0)       tag = "R2";
        else                tag = "R4";
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        repeat (3) cycle(1'b1, 1'b0, 6'h00);
        // fill with an incrementing run: R4 onset, then R2 mapping
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 6'(i + 1));
        // idle stretch: R3
        repeat (6) cycle(1'b0, 1'b0, 6'h15);
        // irregular enables
        for (int i = 0; i < 200; i++) begin
            step_lfsr();
            cycle(1'b0, lfsr[0] | lfsr[3], lfsr[9:4]);
        end
        // mid-stream reset: R7
        cycle(1'b1, 1'b1, 6'h2A);
        for (int i = 0; i < 30; i++) cycle(1'b0, 1'b1, 6'(63 - i));
        // alternating extremes to expose field placement
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, (i % 2 == 1) ? 6'h3F : 6'h00);
        for (int i = 0; i < 1000; i++) begin
            step_lfsr();
            cycle(1'b0, lfsr[2], lfsr[15:10]);
        end
        cycle(1'b0, 1'b0, 6'h00);
        cycle(1'b0, 1'b0, 6'h00);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule